// File: doc/BRIEF.md
# I2C Register-Access Master

This block is an I2C master that reads or writes one byte in a register of an external slave, driven by a single 32-bit command word. Software writes the word with the target slave address, the register index, the direction and, for a write, the data byte, and sets the start bit together with the enable bit. The block then runs the whole bus transaction on its own. Writes send the slave address with the write flag, the register index and the data byte. Reads send the slave address with the write flag and the register index, then a repeated START, the slave address with the read flag, one received byte and a master NACK. Every transaction ends with STOP.

When the transaction ends, the block clears the start bit, which doubles as the busy flag. It also records whether every acknowledge slot saw an ACK. On a successful read it places the fetched byte in the data field. The bus clock comes from a tick prescaler. Each bit period is split into four equal phases of `TICK_DIV` clock cycles. Both bus lines are driven open-drain, as pull-low enables.

Top module: `i2c_regxfer_master`

## Requirements
- R1: After reset, every field of the command word reads 0 and neither bus line is pulled low.
- R2: A write with bit 31 = 1 and bit 23 = 1 while bit 31 reads 0 sets bit 31 on the next clock and starts a transaction. Bit 31 returns to 0 when the STOP condition has been sent.
- R3: A write with bit 23 = 0 starts no transaction. Bit 31 stays 0 and SCL is never pulled low.
- R4: While bit 31 reads 1, any write is ignored: bits 30, 28, 27:26, 23, 22:16 and 15:8 keep their values, and the running transaction is not restarted.
- R5: With bit 30 = 0, the bus carries exactly one START, the byte {address, 0}, the register index (bits 15:8) and the data byte (bits 7:0), then STOP. The slave register receives the data, and bit 24 reads 1.
- R6: With bit 30 = 1, the bus carries two STARTs (the second a repeated START), and the byte is received MSB first. The master answers it with NACK. Bits 7:0 then hold the received byte and bit 24 reads 1.
- R7: If any acknowledge slot sees NAK (SDA high), the master sends STOP right away. Bit 24 reads 0, bits 7:0 keep their previous value and bit 31 clears.
- R8: SCL and SDA never change in the same clock cycle, so SDA moves only while SCL is low, apart from START and STOP. Both lines are released whenever bit 31 is 0.
- R9: Bits 29 and 25 always read 0. Bit 28 and bits 27:26 store the written value and read it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word to write |
| reg_rdata | output | 32 | Current command and status word |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
The assertions take for granted that software never holds the write strobe across a completion in a way that would need to change the address fields. They also assume the SDA input reflects the wired-AND of the master and one well-behaved slave, with no clock stretching. The bench meets both conditions. Its slave model only pulls SDA while SCL is low, and it releases the line on the falling SCL edge of each acknowledge or data bit. Its writes are single-cycle strobes issued at falling clock edges, including the deliberate write during a busy transaction.

// File: rtl/i2c_regxfer_pkg.sv
// Shared types for the I2C register-access master.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_regxfer_pkg;

    // Bus symbol being generated, each four phases long
    typedef enum logic [1:0] {
        SYM_IDLE,
        SYM_START,
        SYM_BIT,
        SYM_STOP
    } sym_e;

    // Byte of the transaction currently on the bus
    typedef enum logic [2:0] {
        STG_ADDR_W,
        STG_REG,
        STG_WDATA,
        STG_ADDR_R,
        STG_RDATA
    } stage_e;

endpackage

// File: rtl/i2c_regxfer_tick.sv
// Phase tick prescaler: pulses once every DIV cycles while run is high.
// Assumes: DIV >= 2; counter restarts from zero whenever run is low.
module i2c_regxfer_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV - 1));

    // Count clock cycles within one phase
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_regxfer_engine.sv
// Transaction engine: sequences START, bytes, acknowledge slots, repeated
// START and STOP. Each symbol spans four phases. SCL is high in phases 1-2,
// and SDA is sampled at the end of phase 2.
// Assumes: addr, regaddr, wdata and rd are held stable from start to done.
module i2c_regxfer_engine
    import i2c_regxfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic       rd,
    input  logic [6:0] addr,
    input  logic [7:0] regaddr,
    input  logic [7:0] wdata,
    input  logic       sda_in,
    output logic       run,
    output logic       done,
    output logic       done_ok,
    output logic [7:0] rx_byte,
    output logic       scl_low,
    output logic       sda_low
);
    sym_e       sym;
    stage_e     stage;
    logic [1:0] phase;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       ack_seen;
    logic       bitval;
    logic       scl_rel;
    logic       sda_rel;

    assign run = (sym != SYM_IDLE);

    // Level the master leaves on SDA during a bit symbol
    assign bitval = (stage == STG_RDATA) || (bitcnt == 4'd8) || shreg[7];

    // Decode line levels from the symbol and the phase
    always_comb begin
        scl_rel = 1'b1;
        sda_rel = 1'b1;
        case (sym)
            SYM_START: begin
                scl_rel = (phase == 2'd1) || (phase == 2'd2);
                sda_rel = (phase < 2'd2);
            end
            SYM_BIT: begin
                scl_rel = (phase == 2'd1) || (phase == 2'd2);
                sda_rel = bitval;
            end
            SYM_STOP: begin
                scl_rel = (phase != 2'd0);
                sda_rel = (phase >= 2'd2);
            end
            default: ;
        endcase
    end

    assign scl_low = !scl_rel;
    assign sda_low = !sda_rel;

    // Step through symbols, bytes and acknowledge slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym      <= SYM_IDLE;
            stage    <= STG_ADDR_W;
            phase    <= 2'd0;
            bitcnt   <= 4'd0;
            shreg    <= 8'd0;
            ack_seen <= 1'b0;
            rx_byte  <= 8'd0;
            done     <= 1'b0;
            done_ok  <= 1'b0;
        end else if (sym == SYM_IDLE) begin
            done <= 1'b0;
            if (start) begin
                sym     <= SYM_START;
                stage   <= STG_ADDR_W;
                phase   <= 2'd0;
                done_ok <= 1'b0;
            end
        end else begin
            done <= 1'b0;
            if (tick) begin
                phase <= phase + 2'd1;
                case (sym)
                    SYM_START: if (phase == 2'd3) begin
                        sym    <= SYM_BIT;
                        bitcnt <= 4'd0;
                        shreg  <= {addr, stage == STG_ADDR_R};
                    end
                    SYM_BIT: begin
                        if (phase == 2'd2) begin
                            if (bitcnt == 4'd8 && stage != STG_RDATA) ack_seen <= !sda_in;
                            else if (bitcnt != 4'd8 && stage == STG_RDATA) rx_byte <= {rx_byte[6:0], sda_in};
                        end
                        if (phase == 2'd3) begin
                            if (bitcnt != 4'd8) begin
                                bitcnt <= bitcnt + 4'd1;
                                shreg  <= {shreg[6:0], 1'b0};
                            end else begin
                                bitcnt <= 4'd0;
                                if (stage != STG_RDATA && !ack_seen) begin
                                    sym <= SYM_STOP;
                                end else begin
                                    case (stage)
                                        STG_ADDR_W: begin
                                            stage <= STG_REG;
                                            shreg <= regaddr;
                                        end
                                        STG_REG: begin
                                            if (rd) begin
                                                sym   <= SYM_START;
                                                stage <= STG_ADDR_R;
                                            end else begin
                                                stage <= STG_WDATA;
                                                shreg <= wdata;
                                            end
                                        end
                                        STG_ADDR_R: stage <= STG_RDATA;
                                        default: begin
                                            sym     <= SYM_STOP;
                                            done_ok <= 1'b1;
                                        end
                                    endcase
                                end
                            end
                        end
                    end
                    SYM_STOP: if (phase == 2'd3) begin
                        sym  <= SYM_IDLE;
                        done <= 1'b1;
                    end
                    default: sym <= SYM_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regxfer_master.sv
// Top: command word register plus prescaler and transaction engine.
// Writes are accepted only while idle. Completion clears the busy bit,
// records the acknowledge result and, on a good read, the received byte.
// Assumes: a single master on the bus and no clock stretching by the slave.
module i2c_regxfer_master #(
    parameter int TICK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        sda_in,
    output logic        scl_drive_low,
    output logic        sda_drive_low
);
    logic       busy, rw, mode_sel, ack_ok, en;
    logic [1:0] dev_sel;
    logic [6:0] slv_addr;
    logic [7:0] reg_idx, data_byte;
    logic       start_req, tick, run, eng_done, eng_ok;
    logic [7:0] eng_rx;
    logic       unused_wbits;

    assign unused_wbits = ^{reg_wdata[29], reg_wdata[25:24]};

    assign start_req = reg_wr && !busy && reg_wdata[31] && reg_wdata[23];

    // Hold command fields; merge completion status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            rw        <= 1'b0;
            mode_sel  <= 1'b0;
            dev_sel   <= 2'd0;
            ack_ok    <= 1'b0;
            en        <= 1'b0;
            slv_addr  <= 7'd0;
            reg_idx   <= 8'd0;
            data_byte <= 8'd0;
        end else if (reg_wr && !busy) begin
            busy      <= reg_wdata[31] && reg_wdata[23];
            rw        <= reg_wdata[30];
            mode_sel  <= reg_wdata[28];
            dev_sel   <= reg_wdata[27:26];
            en        <= reg_wdata[23];
            slv_addr  <= reg_wdata[22:16];
            reg_idx   <= reg_wdata[15:8];
            data_byte <= reg_wdata[7:0];
        end else if (eng_done) begin
            busy   <= 1'b0;
            ack_ok <= eng_ok;
            if (eng_ok && rw) data_byte <= eng_rx;
        end
    end

    assign reg_rdata = {busy, rw, 1'b0, mode_sel, dev_sel, 1'b0, ack_ok, en,
                        slv_addr, reg_idx, data_byte};

    i2c_regxfer_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    i2c_regxfer_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (start_req),
        .rd      (rw),
        .addr    (slv_addr),
        .regaddr (reg_idx),
        .wdata   (data_byte),
        .sda_in  (sda_in),
        .run     (run),
        .done    (eng_done),
        .done_ok (eng_ok),
        .rx_byte (eng_rx),
        .scl_low (scl_drive_low),
        .sda_low (sda_drive_low)
    );
endmodule

// File: rtl/i2c_regxfer_checker.sv
// Protocol and register-behaviour properties for i2c_regxfer_master.
// Assumes: connected through the bind at the bottom of this file.
module i2c_regxfer_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        wr_start,
    input logic        wr_en,
    input logic [31:0] reg_rdata,
    input logic        scl_drive_low,
    input logic        sda_drive_low
);
    // Accepted start with enable raises busy
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rdata[31] && wr_start && wr_en) |=> reg_rdata[31]);

    // Without enable no transaction begins
    p_no_en_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rdata[31] && !wr_en) |=> !reg_rdata[31]);

    // Writes during busy leave the command fields alone
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_rdata[31]) |=> $stable({reg_rdata[30:25], reg_rdata[23:8]}));

    // NAK completion keeps the data field
    p_nak_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(reg_rdata[31]) && !reg_rdata[24]) |-> $stable(reg_rdata[7:0]));

    // SCL and SDA never switch together
    p_no_joint_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_drive_low) |-> $stable(sda_drive_low));

    // Idle means both lines released
    p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |-> (!scl_drive_low && !sda_drive_low));
endmodule

bind i2c_regxfer_master i2c_regxfer_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .wr_start      (reg_wdata[31]),
    .wr_en         (reg_wdata[23]),
    .reg_rdata     (reg_rdata),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low)
);

// File: tb/tb_i2c_regxfer_master.sv
// Directed bench with a behavioural register slave on the wired-AND bus.
module tb_i2c_regxfer_master;
    localparam logic [6:0] SLV = 7'h2A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scl_drive_low, sda_drive_low;
    logic        slv_pull = 1'b0;
    logic        scl_line, sda_line;

    int n_tests = 0, n_fail = 0;
    int n_starts = 0, n_stops = 0, n_scl_fall = 0, n_joint = 0;

    always #4 clk = ~clk;

    assign scl_line = !scl_drive_low;
    assign sda_line = !(sda_drive_low || slv_pull);

    i2c_regxfer_master dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .sda_in        (sda_line),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low)
    );

    // Slave model state
    logic [7:0] mem [0:255];
    logic       p_scl = 1'b1, p_sda = 1'b1, p_sdl = 1'b0, p_sdd = 1'b0;
    logic       active = 1'b0, tx = 1'b0, rwf = 1'b0;
    int         bcnt = 0, bidx = 0;
    logic [7:0] sh = 8'd0, ptr = 8'd0, txb = 8'd0;

    // Behavioural slave and line monitor, evaluated between edges
    always @(negedge clk) begin
        if (!rst_n) begin
            active = 1'b0; tx = 1'b0; slv_pull = 1'b0; bcnt = 0;
        end else begin
            if (scl_drive_low != p_sdl && sda_drive_low != p_sdd) n_joint++;
            if (p_scl && !scl_line) n_scl_fall++;
            if (scl_line && p_scl && p_sda && !sda_line) begin
                n_starts++; active = 1'b1; bcnt = 0; bidx = 0; tx = 1'b0; slv_pull = 1'b0;
            end else if (scl_line && p_scl && !p_sda && sda_line) begin
                n_stops++; active = 1'b0; tx = 1'b0; slv_pull = 1'b0;
            end else if (active && scl_line && !p_scl) begin
                if (!tx && bcnt < 8) sh = {sh[6:0], sda_line};
                bcnt++;
            end else if (active && !scl_line && p_scl) begin
                if (bcnt == 8) begin
                    if (tx) slv_pull = 1'b0;
                    else if (bidx == 0) begin
                        if (sh[7:1] == SLV) begin rwf = sh[0]; slv_pull = 1'b1; end
                        else begin active = 1'b0; slv_pull = 1'b0; end
                    end else if (bidx == 1) begin
                        if (sh == 8'hFF) begin active = 1'b0; slv_pull = 1'b0; end
                        else begin ptr = sh; slv_pull = 1'b1; end
                    end else begin
                        mem[ptr] = sh; slv_pull = 1'b1;
                    end
                end else if (bcnt == 9) begin
                    slv_pull = 1'b0; bcnt = 0;
                    if (tx) tx = 1'b0;
                    else if (bidx == 0 && rwf) begin
                        tx = 1'b1; txb = mem[ptr]; slv_pull = !mem[ptr][7];
                    end
                    bidx++;
                end else if (tx && bcnt >= 1 && bcnt <= 7) begin
                    slv_pull = !txb[7 - bcnt];
                end
            end
            p_scl = scl_line; p_sda = sda_line;
            p_sdl = scl_drive_low; p_sdd = sda_drive_low;
        end
    end

    function automatic logic [31:0] cmd(input logic st, input logic rd, input logic [6:0] a,
                                        input logic [7:0] r, input logic [7:0] d);
        return {st, rd, 6'b000000, 1'b1, a, r, d};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = w;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && reg_rdata[31]; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(reg_rdata == 32'd0, "R1 word", reg_rdata, 32'd0);
        chk(!scl_drive_low && !sda_drive_low, "R1 lines", {scl_drive_low, sda_drive_low}, 0);
    endtask

    task automatic t_write();
        int s0 = n_starts, e0 = n_stops;
        wr(cmd(1'b1, 1'b0, SLV, 8'h10, 8'hA5));
        chk(reg_rdata[31] == 1'b1, "R2 busy set", reg_rdata, 32'h8000_0000);
        wait_done();
        chk(reg_rdata[31] == 1'b0, "R2 busy clear", reg_rdata, 0);
        chk(mem[8'h10] == 8'hA5, "R5 slave data", mem[8'h10], 8'hA5);
        chk(reg_rdata[24] == 1'b1, "R5 ack", reg_rdata, 32'h0100_0000);
        chk(n_starts - s0 == 1 && n_stops - e0 == 1, "R5 one start/stop", n_starts - s0, 1);
        chk(n_joint == 0, "R8 joint edges", n_joint, 0);
    endtask

    task automatic t_read();
        int s0 = n_starts;
        mem[8'h33] = 8'h5C;
        wr(cmd(1'b1, 1'b1, SLV, 8'h33, 8'h00));
        wait_done();
        chk(reg_rdata[7:0] == 8'h5C, "R6 read byte", reg_rdata[7:0], 8'h5C);
        chk(reg_rdata[24] == 1'b1, "R6 ack", reg_rdata, 32'h0100_0000);
        chk(n_starts - s0 == 2, "R6 repeated start", n_starts - s0, 2);
        chk(n_joint == 0, "R8 joint edges read", n_joint, 0);
    endtask

    task automatic t_nak_addr();
        int s0 = n_starts;
        wr(cmd(1'b1, 1'b1, 7'h11, 8'h33, 8'h77));
        wait_done();
        chk(reg_rdata[24] == 1'b0, "R7 addr nak ack", reg_rdata, 0);
        chk(reg_rdata[7:0] == 8'h77, "R7 data kept", reg_rdata[7:0], 8'h77);
        chk(reg_rdata[31] == 1'b0, "R7 busy clear", reg_rdata, 0);
        chk(n_starts - s0 == 1, "R7 no restart", n_starts - s0, 1);
        chk(!scl_drive_low && !sda_drive_low, "R8 released", {scl_drive_low, sda_drive_low}, 0);
    endtask

    task automatic t_nak_reg();
        mem[8'hFF] = 8'h3C;
        wr(cmd(1'b1, 1'b0, SLV, 8'hFF, 8'h99));
        wait_done();
        chk(reg_rdata[24] == 1'b0, "R7 reg nak ack", reg_rdata, 0);
        chk(mem[8'hFF] == 8'h3C, "R7 no data phase", mem[8'hFF], 8'h3C);
    endtask

    task automatic t_disabled();
        int f0 = n_scl_fall;
        logic [31:0] w = cmd(1'b1, 1'b0, SLV, 8'h10, 8'h11);
        w[23] = 1'b0;
        wr(w);
        repeat (300) @(negedge clk);
        chk(reg_rdata[31] == 1'b0, "R3 not busy", reg_rdata, 0);
        chk(n_scl_fall == f0, "R3 no SCL activity", n_scl_fall - f0, 0);
        chk(mem[8'h10] == 8'hA5, "R3 slave untouched", mem[8'h10], 8'hA5);
    endtask

    task automatic t_busy_ignore();
        int s0 = n_starts;
        mem[8'h40] = 8'hC3;
        wr(cmd(1'b1, 1'b1, SLV, 8'h40, 8'h00));
        wr(32'hFFFF_FFFF);
        chk(reg_rdata[30:8] == {1'b1, 6'b000000, 1'b1, SLV, 8'h40}, "R4 fields held",
            reg_rdata[30:8], {1'b1, 6'b000000, 1'b1, SLV, 8'h40});
        wait_done();
        chk(reg_rdata[7:0] == 8'hC3, "R4 read unaffected", reg_rdata[7:0], 8'hC3);
        chk(n_starts - s0 == 2, "R4 no restart", n_starts - s0, 2);
    endtask

    task automatic t_fields();
        wr(32'h3FFF_1234 & ~32'h0080_0000);
        chk(reg_rdata[29] == 1'b0 && reg_rdata[25] == 1'b0, "R9 reserved zero", reg_rdata, 0);
        chk(reg_rdata[28:26] == 3'b111, "R9 mode/devsel stored", reg_rdata[28:26], 3'b111);
        wr(32'h1400_0000);
        chk(reg_rdata[28:26] == 3'b101, "R9 mode/devsel pattern", reg_rdata[28:26], 3'b101);
    endtask

    initial begin
        bit timeout = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_write();
                t_read();
                t_nak_addr();
                t_nak_reg();
                t_disabled();
                t_busy_ignore();
                t_fields();
            end
            begin
                repeat (150000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=expired expected=completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule